// File: doc/BRIEF.md
# Flash Buffered-Program Command Interpreter

This block models the device-side command interpreter of a flash part for a buffered program sequence. It sees bus write cycles (address, data, write enable) and an active-low output enable, and answers reads on a single data bus. A setup command opens the sequence and latches the block being addressed. Reads then show an extended status word that reports whether the buffer is free. The next write gives an element count N, and N+1 data writes follow. The first of these sets the destination start address. A confirm command then hands the buffer to a programming phase. That phase copies one element per clock into a small register array that stands in for the flash cells, then stays busy for a parameterised number of extra cycles.

While the part is busy, the main status word shows bit 7 low. Status reads come from a snapshot. The snapshot is refreshed after every bus write and after every high-to-low transition of the output enable, so a host can poll by toggling the enable. Breaking the protocol aborts the sequence and leaves a sticky improper-sequence flag in status. The protocol is broken by a count above the mode limit, a data write outside the latched block, or a wrong confirm code.

Top module: `fbuf_cmd_top`

## Requirements
- R1: After reset the interpreter is in read-array mode, every array word reads 0000h, and a following read-status command (write of 70h) shows status 0080h.
- R2: A write of E8h from read-array or status mode enters buffer setup and latches the block (address bits above the block offset). Reads in setup return the extended status 0080h (bit 7 = 1: buffer free).
- R3: In setup the next write is the count N. N is accepted when N ≤ 31 with byte_mode_i = 1, or N ≤ 15 with byte_mode_i = 0. Reads then return main status, 0080h, and no longer the extended status.
- R4: A count above the selected limit aborts. Status then reads 00B0h: bit 7 ready, and bits 5 and 4 both set as the improper-sequence flag.
- R5: Exactly N+1 data writes follow the count, and the first one sets the start address S. After programming, array word (S+k) mod array size holds data element k for k = 0..N. All other words are unchanged.
- R6: A data write whose block differs from the latched block aborts with status 00B0h, and the array is left unchanged.
- R7: The low byte D0h written after the last element starts programming, and status bit 7 reads 0 (status 0000h). After N+1+PROG_CYCLES busy cycles, bit 7 reads 1 at the next refresh. Any other confirm value aborts with 00B0h and nothing is programmed.
- R8: The status snapshot is refreshed only after a bus write or a high-to-low transition of oe_ni. Without either, it holds its old value, even after programming has finished.
- R9: Writes during the busy phase are ignored. A write of FFh while busy does not leave status mode and does not end the busy phase.
- R10: From read-array or status mode, FFh selects read-array mode, 70h selects status mode, and 50h clears the improper-sequence flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe, one write per high cycle |
| addr_i | input | AW | Word address for writes and array reads |
| wdata_i | input | DW | Write data; commands sit in bits 7:0 |
| oe_ni | input | 1 | Active-low output enable; its falling edge refreshes status |
| byte_mode_i | input | 1 | Selects the byte-mode count limit (1) or the word-mode limit (0) |
| rdata_o | output | DW | Array word, extended status or status snapshot, depending on mode |

## Verification
A bus write takes effect at the clock edge that samples it. Array reads and the extended status are combinational from that state, so they are valid in the next low clock phase. The status snapshot reloads one edge later. For this reason the bench's write task waits one more falling edge before it returns, and status is always sampled two falling edges after the write. An output-enable toggle drives the pin low on a falling edge, and the snapshot is checked two falling edges later. The end of programming is checked twice: a sample taken after the busy window but before any refresh must still show busy, and a sample taken after a toggle must show ready.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
  typedef enum logic [2:0] {
    ST_ARRAY,
    ST_STATUS,
    ST_SETUP,
    ST_LOAD,
    ST_CONFIRM,
    ST_BUSY
  } fb_state_e;

  typedef enum logic [1:0] {
    RD_ARRAY,
    RD_XSTAT,
    RD_STAT
  } rd_sel_e;

  localparam logic [7:0] CMD_BUF_SETUP = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_RD_STAT   = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
endpackage

// File: rtl/fbuf_ctrl.sv
module fbuf_ctrl
  import fbuf_pkg::*;
#(
  parameter int AW          = 7,
  parameter int DW          = 16,
  parameter int BUF_AW      = 5,
  parameter int BLK_AW      = 5,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              byte_mode_i,
  output fb_state_e         state_o,
  output logic              err_o,
  output logic              buf_we_o,
  output logic [BUF_AW-1:0] buf_idx_o,
  output logic [DW-1:0]     buf_wdata_o,
  output logic              prog_we_o,
  output logic [BUF_AW-1:0] prog_idx_o,
  output logic [AW-1:0]     prog_addr_o
);
  localparam int BLKW = AW - BLK_AW;
  localparam logic [DW-1:0] BYTE_MAX = DW'(2**BUF_AW - 1);
  localparam logic [DW-1:0] WORD_MAX = DW'(2**(BUF_AW-1) - 1);
  localparam int TW = $clog2(2**BUF_AW + PROG_CYCLES + 1);

  fb_state_e         state_q, state_d;
  logic              err_q, err_d;
  logic [BLKW-1:0]   blk_q, blk_d;
  logic [AW-1:0]     start_q, start_d;
  logic [BUF_AW-1:0] cnt_q, cnt_d;
  logic [BUF_AW-1:0] idx_q, idx_d;
  logic [TW-1:0]     t_q, t_d;

  logic [7:0] cmd;
  logic       in_blk;
  logic       cnt_ok;
  logic       prog_done;

  assign cmd       = wdata_i[7:0];
  assign in_blk    = (addr_i[AW-1:BLK_AW] == blk_q);
  assign cnt_ok    = wdata_i <= (byte_mode_i ? BYTE_MAX : WORD_MAX);
  assign prog_done = (t_q == TW'(cnt_q) + TW'(PROG_CYCLES));

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    blk_d   = blk_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    t_d     = t_q;
    unique case (state_q)
      ST_ARRAY, ST_STATUS: begin
        if (wr_en_i) begin
          case (cmd)
            CMD_BUF_SETUP: begin
              state_d = ST_SETUP;
              blk_d   = addr_i[AW-1:BLK_AW];
            end
            CMD_RD_ARRAY: state_d = ST_ARRAY;
            CMD_RD_STAT:  state_d = ST_STATUS;
            CMD_CLR_STAT: err_d   = 1'b0;
            default: ;
          endcase
        end
      end
      ST_SETUP: begin
        if (wr_en_i) begin
          if (cnt_ok) begin
            cnt_d   = wdata_i[BUF_AW-1:0];
            idx_d   = '0;
            state_d = ST_LOAD;
          end else begin
            err_d   = 1'b1;
            state_d = ST_STATUS;
          end
        end
      end
      ST_LOAD: begin
        if (wr_en_i) begin
          if (!in_blk) begin
            err_d   = 1'b1;
            state_d = ST_STATUS;
          end else begin
            if (idx_q == '0) start_d = addr_i;
            if (idx_q == cnt_q) state_d = ST_CONFIRM;
            else                idx_d   = idx_q + 1'b1;
          end
        end
      end
      ST_CONFIRM: begin
        if (wr_en_i) begin
          if (cmd == CMD_CONFIRM) begin
            state_d = ST_BUSY;
            t_d     = '0;
          end else begin
            err_d   = 1'b1;
            state_d = ST_STATUS;
          end
        end
      end
      ST_BUSY: begin
        t_d = t_q + 1'b1;
        if (prog_done) state_d = ST_STATUS;
      end
      default: state_d = ST_ARRAY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARRAY;
      err_q   <= 1'b0;
      blk_q   <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      t_q     <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      blk_q   <= blk_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      t_q     <= t_d;
    end
  end

  assign state_o     = state_q;
  assign err_o       = err_q;
  assign buf_we_o    = wr_en_i && (state_q == ST_LOAD) && in_blk;
  assign buf_idx_o   = idx_q;
  assign buf_wdata_o = wdata_i;
  assign prog_we_o   = (state_q == ST_BUSY) && (t_q <= TW'(cnt_q));
  assign prog_idx_o  = t_q[BUF_AW-1:0];
  assign prog_addr_o = start_q + AW'(t_q[BUF_AW-1:0]);

  // R4
  cnt_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETUP && wr_en_i && !cnt_ok) |=> (err_o && state_o == ST_STATUS));

  // R6
  blk_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && wr_en_i && !in_blk) |=> (err_o && !prog_we_o && state_o == ST_STATUS));

  // R7
  bad_confirm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONFIRM && wr_en_i && cmd != CMD_CONFIRM) |=> (err_o && state_o != ST_BUSY));

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY && !prog_done) |=>
      (state_q == ST_BUSY && $stable(err_q) && $stable(start_q) && $stable(cnt_q)));
endmodule

// File: rtl/fbuf_store.sv
module fbuf_store #(
  parameter int AW     = 7,
  parameter int DW     = 16,
  parameter int BUF_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              buf_we_i,
  input  logic [BUF_AW-1:0] buf_idx_i,
  input  logic [DW-1:0]     buf_wdata_i,
  input  logic              prog_we_i,
  input  logic [BUF_AW-1:0] prog_idx_i,
  input  logic [AW-1:0]     prog_addr_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DW-1:0]     rd_data_o
);
  localparam int BUF_DEPTH = 2**BUF_AW;
  localparam int ARR_WORDS = 2**AW;

  logic [DW-1:0] buf_q [BUF_DEPTH];
  logic [DW-1:0] arr_q [ARR_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BUF_DEPTH; i++) buf_q[i] <= '0;
    end else if (buf_we_i) begin
      buf_q[buf_idx_i] <= buf_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ARR_WORDS; i++) arr_q[i] <= '0;
    end else if (prog_we_i) begin
      arr_q[prog_addr_i] <= buf_q[prog_idx_i];
    end
  end

  assign rd_data_o = arr_q[rd_addr_i];
endmodule

// File: rtl/fbuf_status.sv
module fbuf_status
  import fbuf_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          oe_ni,
  input  rd_sel_e       sel_i,
  input  logic          busy_i,
  input  logic          err_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] rdata_o
);
  localparam int PADW = DW - 8;

  logic       oe_prev_q;
  logic       oe_fall;
  logic       refresh_q;
  logic [7:0] live_sr;
  logic [7:0] snap_q;
  logic [7:0] xsr;

  assign oe_fall = oe_prev_q && !oe_ni;
  assign live_sr = {!busy_i, 1'b0, err_i, err_i, 4'b0000};
  assign xsr     = {!busy_i, 7'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_prev_q <= 1'b1;
      refresh_q <= 1'b0;
      snap_q    <= 8'h80;
    end else begin
      oe_prev_q <= oe_ni;
      refresh_q <= wr_en_i || oe_fall;
      if (refresh_q) snap_q <= live_sr;
    end
  end

  always_comb begin
    unique case (sel_i)
      RD_ARRAY: rdata_o = arr_data_i;
      RD_XSTAT: rdata_o = {{PADW{1'b0}}, xsr};
      default:  rdata_o = {{PADW{1'b0}}, snap_q};
    endcase
  end

  // R2
  xsr_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == RD_XSTAT) |-> rdata_o[7]);
endmodule

// File: rtl/fbuf_cmd_top.sv
module fbuf_cmd_top
  import fbuf_pkg::*;
#(
  parameter int AW          = 7,
  parameter int DW          = 16,
  parameter int BUF_AW      = 5,
  parameter int BLK_AW      = 5,
  parameter int PROG_CYCLES = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          oe_ni,
  input  logic          byte_mode_i,
  output logic [DW-1:0] rdata_o
);
  fb_state_e         state;
  rd_sel_e           sel;
  logic              err;
  logic              buf_we;
  logic [BUF_AW-1:0] buf_idx;
  logic [DW-1:0]     buf_wdata;
  logic              prog_we;
  logic [BUF_AW-1:0] prog_idx;
  logic [AW-1:0]     prog_addr;
  logic [DW-1:0]     arr_data;

  fbuf_ctrl #(
    .AW(AW), .DW(DW), .BUF_AW(BUF_AW), .BLK_AW(BLK_AW), .PROG_CYCLES(PROG_CYCLES)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .byte_mode_i (byte_mode_i),
    .state_o     (state),
    .err_o       (err),
    .buf_we_o    (buf_we),
    .buf_idx_o   (buf_idx),
    .buf_wdata_o (buf_wdata),
    .prog_we_o   (prog_we),
    .prog_idx_o  (prog_idx),
    .prog_addr_o (prog_addr)
  );

  fbuf_store #(.AW(AW), .DW(DW), .BUF_AW(BUF_AW)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .buf_we_i    (buf_we),
    .buf_idx_i   (buf_idx),
    .buf_wdata_i (buf_wdata),
    .prog_we_i   (prog_we),
    .prog_idx_i  (prog_idx),
    .prog_addr_i (prog_addr),
    .rd_addr_i   (addr_i),
    .rd_data_o   (arr_data)
  );

  always_comb begin
    unique case (state)
      ST_ARRAY: sel = RD_ARRAY;
      ST_SETUP: sel = RD_XSTAT;
      default:  sel = RD_STAT;
    endcase
  end

  fbuf_status #(.DW(DW)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .oe_ni      (oe_ni),
    .sel_i      (sel),
    .busy_i     (state == ST_BUSY),
    .err_i      (err),
    .arr_data_i (arr_data),
    .rdata_o    (rdata_o)
  );
endmodule

// File: tb/tb_fbuf_cmd_top.sv
module tb_fbuf_cmd_top;
  localparam int AW = 7;
  localparam int DW = 16;
  localparam int PROG = 20;
  localparam int WORDS = 2**AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          oe_n = 1'b1;
  logic          bmode = 1'b0;
  logic [DW-1:0] rdata;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] shadow [WORDS];

  always #10 clk = ~clk;

  fbuf_cmd_top #(.AW(AW), .DW(DW), .PROG_CYCLES(PROG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .oe_ni(oe_n), .byte_mode_i(bmode), .rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic oe_pulse();
    @(negedge clk); oe_n = 1'b1;
    @(negedge clk); oe_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_array(input string tag);
    for (int a = 0; a < WORDS; a++) begin
      addr = AW'(a);
      #1;
      chk(tag, rdata, shadow[a]);
    end
  endtask

  task automatic run_prog(input logic bm, input int n, input int start, input logic [DW-1:0] seed);
    int base;
    logic [DW-1:0] d;
    base = start & ~31;
    bmode = bm;
    wr(base, 16'h00E8);
    chk("R2 extended status in setup", rdata, 16'h0080);
    wr(base, DW'(n));
    chk("R3 status after count", rdata, 16'h0080);
    for (int k = 0; k <= n; k++) begin
      d = seed ^ DW'(k * 16'h0101);
      shadow[(start + k) % WORDS] = d;
      wr((k == 0) ? start : base + (k % 32), d);
    end
    wr(base, 16'h00D0);
    chk("R7 busy after confirm", rdata, 16'h0000);
    wr(base, 16'h00FF);
    chk("R9 FFh ignored while busy", rdata, 16'h0000);
    repeat (n + PROG + 6) @(negedge clk);
    chk("R8 snapshot held without refresh", rdata, 16'h0000);
    oe_pulse();
    chk("R7 ready after oe refresh", rdata, 16'h0080);
    wr(0, 16'h00FF);
    check_array("R5 array after program");
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < WORDS; a++) shadow[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < WORDS; a += 17) begin
      addr = AW'(a); #1;
      chk("R1 array zero after reset", rdata, 16'h0000);
    end
    wr(0, 16'h0070);
    chk("R1 status after reset", rdata, 16'h0080);
    wr(0, 16'h00FF);
    addr = 7'd3; #1;
    chk("R10 FFh back to array", rdata, 16'h0000);

    // R4 count limits
    bmode = 1'b0;
    wr(0, 16'h00E8);
    wr(0, 16'd16);
    chk("R4 word count 16 rejected", rdata, 16'h00B0);
    wr(0, 16'h0050);
    chk("R10 clear status", rdata, 16'h0080);
    bmode = 1'b1;
    wr(0, 16'h00E8);
    wr(0, 16'd32);
    chk("R4 byte count 32 rejected", rdata, 16'h00B0);
    wr(0, 16'h0050);
    wr(0, 16'h00E8);
    wr(0, 16'h1000);
    chk("R4 large count rejected", rdata, 16'h00B0);
    wr(0, 16'h0050);

    // R3/R5/R7 sweeps
    run_prog(1'b0, 0, 5, 16'h1234);
    run_prog(1'b0, 1, 37, 16'hA5C3);
    run_prog(1'b0, 7, 64, 16'h0F0F);
    run_prog(1'b0, 15, 100, 16'h7E81);
    run_prog(1'b1, 16, 30, 16'hC001);
    run_prog(1'b1, 31, 127, 16'h5A5A);

    // R6 out-of-block abort
    bmode = 1'b0;
    wr(40, 16'h00E8);
    wr(40, 16'd3);
    wr(41, 16'hDEAD);
    wr(70, 16'hBEEF);
    chk("R6 out-of-block abort", rdata, 16'h00B0);
    wr(41, 16'h00D0);
    chk("R6 confirm after abort ignored", rdata, 16'h00B0);
    wr(0, 16'h0050);
    wr(0, 16'h00FF);
    check_array("R6 array unchanged");

    // R7 bad confirm
    wr(10, 16'h00E8);
    wr(10, 16'd0);
    wr(10, 16'h4321);
    wr(10, 16'h0055);
    chk("R7 bad confirm abort", rdata, 16'h00B0);
    oe_pulse();
    chk("R8 oe refresh keeps flag", rdata, 16'h00B0);
    wr(0, 16'h0050);
    chk("R10 clear after bad confirm", rdata, 16'h0080);
    wr(0, 16'h00FF);
    check_array("R7 array unchanged after bad confirm");
    wr(0, 16'h0070);
    chk("R10 70h selects status", rdata, 16'h0080);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule